// File: doc/BRIEF.md
# Serial-Parallel Shift-Add Multiplier

This block multiplies two unsigned numbers over several clock cycles. The multiplicand is captured in parallel and held in a register. The multiplier is loaded into the low half of a shift register and is used one bit per clock, least significant bit first. On each step a single adder, only as wide as the multiplicand, adds either the multiplicand or zero into the upper half of the accumulator. The accumulator and the multiplier register then shift right together by one place. The adder's carry-out enters the top bit, and the lowest sum bit moves into the space left by the consumed multiplier bit.

A client raises `start` for one cycle while the unit is idle. `busy` then stays high for exactly one step per multiplier bit. `done` pulses for one cycle when the last step completes, and at that point `product` holds the double-width result. The result stays on `product` until the next accepted start. A start that arrives during a multiply is ignored. The adder is built from a parameter-selected variant: either a behavioural sum or an explicit ripple chain of full adders.

Top module: `shiftadd_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: When `done` is 1, `product` equals the unsigned product of the `mcand` and `mplr` values sampled at the accepted start, for every operand pair.
- R3: A start accepted at a clock edge (`start`=1 while `busy`=0) makes `busy` 1 from that edge on, for exactly MPLR_W cycles.
- R4: `done` is 1 for exactly one cycle. That cycle is the one in which `busy` has just returned to 0, MPLR_W clock edges after the accepting edge.
- R5: `start`=1 while `busy`=1 is ignored. The running multiply keeps its timing and its result.
- R6: Changes on `mcand` and `mplr` after the accepting edge do not affect the result.
- R7: While idle and with no new start, `product` holds its value unchanged.
- R8: The adder carry is kept. All-ones operands give (2^MCAND_W-1)*(2^MPLR_W-1).
- R9: A start given in the same cycle that `done` is 1 is accepted, and the new multiply proceeds with normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiply when idle |
| mcand | input | MCAND_W | Multiplicand, held in parallel |
| mplr | input | MPLR_W | Multiplier, consumed LSB first |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: result ready |
| product | output | MCAND_W+MPLR_W | Unsigned product |

## Verification
The accepting edge is the reference point. `busy` must read 1 in the half-cycle after that edge and after each of the next MPLR_W-1 edges. `done` and the result are due after exactly MPLR_W edges, and `done` must be low again one cycle later. The bench drives inputs on falling edges and samples on falling edges, so it reads each output in the cycle it is due. It sweeps every operand pair of a 6x5 configuration. It also injects starts and operand changes mid-multiply, back-to-back starts, and idle hold periods.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;
   typedef enum logic {
      ADD_BEHAV  = 1'b0,
      ADD_RIPPLE = 1'b1
   } adder_kind_e;
endpackage

// File: rtl/shiftadd_adder.sv
module shiftadd_adder
   import shiftadd_pkg::*;
#(
   parameter int          W    = 8,
   parameter adder_kind_e KIND = ADD_RIPPLE
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] s,
   output logic         co
);
   if (KIND == ADD_RIPPLE) begin : g_ripple
      logic [W:0] c;
      assign c[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_fa
         assign s[i]   = a[i] ^ b[i] ^ c[i];
         assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
      end
      assign co = c[W];
   end else begin : g_behav
      assign {co, s} = {1'b0, a} + {1'b0, b};
   end
endmodule

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl #(
   parameter int STEPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(STEPS + 1);
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   logic [CW-1:0] cnt;

   assign load = start & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            cnt  <= '0;
            busy <= 1'b1;
         end else if (busy) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/shiftadd_dp.sv
module shiftadd_dp
   import shiftadd_pkg::*;
#(
   parameter int          M    = 8,
   parameter int          N    = 8,
   parameter adder_kind_e KIND = ADD_RIPPLE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [M-1:0] mcand,
   input  logic [N-1:0] mplr,
   output logic [M+N-1:0] product
);
   logic [M-1:0] icand_q;
   logic [M-1:0] hi_q;
   logic [N-1:0] lo_q;
   logic [M-1:0] addend;
   logic [M-1:0] sum;
   logic         carry;

   assign addend = lo_q[0] ? icand_q : '0;

   shiftadd_adder #(.W(M), .KIND(KIND)) u_add (
      .a  (hi_q),
      .b  (addend),
      .s  (sum),
      .co (carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         icand_q <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else if (load) begin
         icand_q <= mcand;
         hi_q    <= '0;
         lo_q    <= mplr;
      end else if (step) begin
         hi_q <= {carry, sum[M-1:1]};
         lo_q <= {sum[0], lo_q[N-1:1]};
      end
   end

   assign product = {hi_q, lo_q};
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
   import shiftadd_pkg::*;
#(
   parameter int          MCAND_W = 6,
   parameter int          MPLR_W  = 5,
   parameter adder_kind_e ADDER   = ADD_RIPPLE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [MCAND_W-1:0]         mcand,
   input  logic [MPLR_W-1:0]          mplr,
   output logic                       busy,
   output logic                       done,
   output logic [MCAND_W+MPLR_W-1:0]  product
);
   if (MCAND_W < 2) begin : g_bad_m
      $error("MCAND_W must be at least 2");
   end
   if (MPLR_W < 2) begin : g_bad_n
      $error("MPLR_W must be at least 2");
   end

   logic load;

   shiftadd_ctrl #(.STEPS(MPLR_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .busy  (busy),
      .done  (done)
   );

   shiftadd_dp #(.M(MCAND_W), .N(MPLR_W), .KIND(ADDER)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (busy),
      .mcand   (mcand),
      .mplr    (mplr),
      .product (product)
   );
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
   parameter int M = 6,
   parameter int N = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [M-1:0]   mcand,
   input logic [N-1:0]   mplr,
   input logic           busy,
   input logic           done,
   input logic [M+N-1:0] product
);
   localparam int PW = M + N;
   localparam int CW = $clog2(N + 2);

   logic [M-1:0]  a_q;
   logic [N-1:0]  b_q;
   logic [CW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         run <= '0;
      end else begin
         if (start && !busy) begin
            a_q <= mcand;
            b_q <= mplr;
         end
         if (busy) run <= run + 1'b1;
         else      run <= '0;
      end
   end

   // R2, R5, R6, R8
   a_r2_product_ok: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> product == PW'(PW'(a_q) * PW'(b_q)));
   // R3
   a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run < CW'(N));
   // R4
   a_r4_done_after_n: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && run == CW'(N)));
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R7
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.M(MCAND_W), .N(MPLR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mcand   (mcand),
   .mplr    (mplr),
   .busy    (busy),
   .done    (done),
   .product (product)
);

// File: tb/tb_shiftadd_mul.sv
`timescale 1ns/1ps
module tb_shiftadd_mul;
   localparam int M  = 6;
   localparam int N  = 5;
   localparam int PW = M + N;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [M-1:0]  mcand = '0;
   logic [N-1:0]  mplr = '0;
   logic          busy;
   logic          done;
   logic [PW-1:0] product;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   shiftadd_mul #(.MCAND_W(M), .MPLR_W(N)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplr(mplr),
      .busy(busy), .done(done), .product(product)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Called at a falling edge: asserts start, returns at the falling edge after the accepting edge.
   task automatic launch(input int a, input int b);
      start = 1'b1;
      mcand = M'(a);
      mplr  = N'(b);
      @(negedge clk);
      start = 1'b0;
   endtask

   // poke: 0 none, 1 start with other operands mid-run, 2 operand change only
   task automatic finish_run(input int a, input int b, input int poke);
      bit tim_ok = 1'b1;
      longint exp = longint'(a) * longint'(b);
      chk(busy === 1'b1 && done === 1'b0, "R3 busy after accept", busy, 1);
      for (int k = 1; k < N; k++) begin
         if (k == 1 && poke != 0) begin
            start = (poke == 1);
            mcand = M'(a + 13);
            mplr  = N'(b + 7);
         end
         @(negedge clk);
         start = 1'b0;
         if (busy !== 1'b1 || done !== 1'b0) tim_ok = 1'b0;
      end
      chk(tim_ok, "R3 busy held N cycles", tim_ok, 1);
      @(negedge clk);
      chk(done === 1'b1 && busy === 1'b0, "R4 done at N edges", {busy, done}, 1);
      chk(product == PW'(exp), poke == 1 ? "R5 product" : (poke == 2 ? "R6 product" : "R2 product"),
          product, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [PW-1:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0, "R1 busy", busy, 0);
      chk(done === 1'b0, "R1 done", done, 0);
      chk(product === '0, "R1 product", product, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 exhaustive sweep
      for (int a = 0; a < (1 << M); a++) begin
         for (int b = 0; b < (1 << N); b++) begin
            launch(a, b);
            finish_run(a, b, 0);
            @(negedge clk);
            chk(done === 1'b0, "R4 done one cycle", done, 0);
         end
      end

      // R8 all ones
      launch((1 << M) - 1, (1 << N) - 1);
      finish_run((1 << M) - 1, (1 << N) - 1, 0);
      @(negedge clk);

      // R5 start while busy
      launch(45, 27);
      finish_run(45, 27, 1);
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R5 no extra run", {busy, done}, 0);

      // R6 operand change mid-run
      launch(19, 30);
      finish_run(19, 30, 2);

      // R7 idle hold
      held = product;
      mcand = '1;
      mplr  = '1;
      repeat (6) @(negedge clk);
      chk(product == held && busy === 1'b0, "R7 hold idle", product, held);

      // R9 back-to-back start in done cycle
      launch(50, 11);
      finish_run(50, 11, 0);
      launch(33, 29);
      finish_run(33, 29, 0);
      @(negedge clk);
      chk(done === 1'b0, "R9 done single", done, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule